// File: doc/BRIEF.md
# Masked Interrupt Combiner with Write-1-to-Clear Events

This block gathers eight interrupt sources into one flag byte and merges them, through a per-bit enable byte, onto a single active-low interrupt pin. The low four flag bits are live copies of four socket interrupt levels. Those levels are produced elsewhere, and the bits clear only when their sources drop. The upper three flag bits are sticky event flags. Each is set by a one-cycle pulse: a session-closed event, a destination-unreachable event or an address-conflict event. Each stays set until the host writes a 1 to its position.

The host reaches both bytes through a small register port. There is a write strobe, a one-bit select, write data and a combinational read-data bus. Select 0 addresses the flag byte and select 1 addresses the mask byte. Typical use: enable the sources of interest in the mask, wait for the pin to fall, read the flags, service the sockets, and clear the events that were seen by writing them back.

Top module: `irq_combiner`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) clears the mask byte to 0x00 and all event flags, so `irq_n` is high after reset.
- R2: Flag bits 3..0 read back `sock_irq[3:0]` with no clock delay, and a change on `sock_irq` reaches `irq_n` in the same cycle.
- R3: Flag bit 4 always reads 0, whatever the mask or writes.
- R4: A one-cycle pulse on `evt_sess_closed`, `evt_unreach` or `evt_addr_clash` sets flag bit 5, 6 or 7 respectively at the next rising clock edge. The bit then holds until cleared.
- R5: A write with `reg_sel`=0 clears each of flag bits 7..5 whose `reg_wdata` bit is 1, from the next edge on. Bits written with 0 keep their value.
- R6: Writing to flag bits 4..0 has no effect on the flag byte.
- R7: If an event pulse and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R8: A write with `reg_sel`=1 loads all eight mask bits from `reg_wdata` at the next edge. Reading with `reg_sel`=1 returns the mask.
- R9: `irq_n` is low exactly when some flag bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sock_irq | input | 4 | Socket interrupt levels, bit n for socket n |
| evt_sess_closed | input | 1 | Pulse: dial-up session closed (flag bit 5) |
| evt_unreach | input | 1 | Pulse: destination unreachable (flag bit 6) |
| evt_addr_clash | input | 1 | Pulse: address conflict seen (flag bit 7) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects flag byte, 1 selects mask byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected byte (combinational) |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled at the clock edge. They also assume that register writes are synchronous one-cycle strobes, and that the socket levels may change at any time between edges. The stimulus follows these assumptions. Every input changes on the falling clock edge, and each event line is held high for exactly one cycle, so that every pulse and write is seen at exactly one rising edge. Socket levels are held steady across an edge in the table walk. The socket levels are changed only between edges in the directed test that checks the combinational path.

// File: rtl/irq_combiner.sv
module irq_combiner (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sock_irq,
  input  logic       evt_sess_closed,
  input  logic       evt_unreach,
  input  logic       evt_addr_clash,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_n
);
  localparam logic SEL_FLAG = 1'b0;
  localparam logic SEL_MASK = 1'b1;

  logic [2:0] evt_q;
  logic [7:0] mask_q;
  logic [2:0] evt_in;
  logic [2:0] evt_clr;
  logic [7:0] flags;

  assign evt_in  = {evt_addr_clash, evt_unreach, evt_sess_closed};
  assign evt_clr = (reg_wr && reg_sel == SEL_FLAG) ? reg_wdata[7:5] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 3'b000;
    else        evt_q <= (evt_q & ~evt_clr) | evt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mask_q <= 8'h00;
    else if (reg_wr && reg_sel == SEL_MASK) mask_q <= reg_wdata;
  end

  assign flags     = {evt_q, 1'b0, sock_irq};
  assign reg_rdata = (reg_sel == SEL_MASK) ? mask_q : flags;
  assign irq_n     = ~|(flags & mask_q);
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] sock_irq,
  input logic [2:0] ev,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq_n,
  input logic [2:0] evt_q,
  input logic [7:0] mask_q
);
  for (genvar i = 0; i < 3; i++) begin : g_evt
    // R4
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> evt_q[i]);
    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && reg_wr && !reg_sel && reg_wdata[5+i]) |=> evt_q[i]);
    // R5
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev[i] && reg_wr && !reg_sel && reg_wdata[5+i]) |=> !evt_q[i]);
    // R5
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev[i] && !(reg_wr && !reg_sel && reg_wdata[5+i])) |=> $stable(evt_q[i]));
  end

  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> mask_q == $past(reg_wdata));
  // R8
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel) |=> $stable(mask_q));
  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> !reg_rdata[4]);
  // R2
  sock_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> reg_rdata[3:0] == sock_irq);
  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> irq_n);
  // R9
  sock_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sock_irq & mask_q[3:0])) |-> !irq_n);
endmodule

bind irq_combiner irq_combiner_chk chk (
  .clk(clk), .rst_n(rst_n), .sock_irq(sock_irq), .ev(evt_in),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_n(irq_n), .evt_q(evt_q), .mask_q(mask_q)
);

// File: tb/irq_combiner_test.sv
module irq_combiner_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sock_irq = '0;
  logic ev_closed = 1'b0, ev_unreach = 1'b0, ev_clash = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_n;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  irq_combiner uut (
    .clk(clk), .rst_n(rst_n), .sock_irq(sock_irq),
    .evt_sess_closed(ev_closed), .evt_unreach(ev_unreach), .evt_addr_clash(ev_clash),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // {sock, ev{clash,unreach,closed}, wr, sel, wdata, exp_flag, exp_mask, exp_irqn}
  localparam logic [33:0] VEC [12] = '{
    {4'b0001, 3'b000, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 1'b1}, // R2 R9 masked
    {4'b0001, 3'b000, 1'b1, 1'b1, 8'h01, 8'h01, 8'h01, 1'b0}, // R8 R9
    {4'b0000, 3'b001, 1'b0, 1'b0, 8'h00, 8'h20, 8'h01, 1'b1}, // R4 bit5
    {4'b0000, 3'b000, 1'b1, 1'b1, 8'h20, 8'h20, 8'h20, 1'b0}, // R8 R9
    {4'b0000, 3'b010, 1'b0, 1'b0, 8'h00, 8'h60, 8'h20, 1'b0}, // R4 bit6
    {4'b0000, 3'b000, 1'b1, 1'b0, 8'h20, 8'h40, 8'h20, 1'b1}, // R5
    {4'b1010, 3'b100, 1'b1, 1'b0, 8'h1F, 8'hCA, 8'h20, 1'b1}, // R4 bit7, R6
    {4'b1010, 3'b001, 1'b1, 1'b0, 8'h20, 8'hEA, 8'h20, 1'b0}, // R7
    {4'b1010, 3'b000, 1'b1, 1'b0, 8'hE0, 8'h0A, 8'h20, 1'b1}, // R5 all
    {4'b0100, 3'b000, 1'b1, 1'b1, 8'hFF, 8'h04, 8'hFF, 1'b0}, // R3 R8
    {4'b0000, 3'b010, 1'b0, 1'b0, 8'h00, 8'h40, 8'hFF, 1'b0}, // R4
    {4'b0000, 3'b000, 1'b1, 1'b0, 8'h9F, 8'h40, 8'hFF, 1'b0}  // R5 zero keeps
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R2/R9";  1: return "R8/R9";  2: return "R4";  3: return "R8";
      4: return "R4";     5: return "R5";     6: return "R4/R6"; 7: return "R7";
      8: return "R5";     9: return "R3/R8";  10: return "R4"; default: return "R5";
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_all();
    #5 rst_n = 1'b0;
    @(negedge clk);
    reg_sel = 1'b0; #1 check("R1", "flags in reset", reg_rdata, 8'h00);
    reg_sel = 1'b1; #1 check("R1", "mask in reset", reg_rdata, 8'h00);
    check("R1", "irq_n in reset", {7'b0, irq_n}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      logic [33:0] v;
      v = VEC[i];
      sock_irq = v[33:30];
      {ev_clash, ev_unreach, ev_closed} = v[29:27];
      reg_wr = v[26]; reg_sel = v[25]; reg_wdata = v[24:17];
      @(posedge clk);
      @(negedge clk);
      {ev_clash, ev_unreach, ev_closed} = 3'b000;
      reg_wr = 1'b0; reg_sel = 1'b0;
      #1 check(vec_req(i), $sformatf("vec %0d flags", i), reg_rdata, v[16:9]);
      reg_sel = 1'b1;
      #1 check(vec_req(i), $sformatf("vec %0d mask", i), reg_rdata, v[8:1]);
      check(vec_req(i), $sformatf("vec %0d irq_n", i), {7'b0, irq_n}, {7'b0, v[0]});
    end
    // R5: clear remaining bit6, then R2/R9 combinational path without a clock edge
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h40;
    @(negedge clk);
    reg_wr = 1'b0;
    #1 check("R5", "bit6 cleared", reg_rdata, 8'h00);
    check("R9", "irq_n idle", {7'b0, irq_n}, 8'h01);
    sock_irq = 4'b1000;
    #1 check("R2", "socket 3 mirrored at once", reg_rdata, 8'h08);
    check("R9", "irq_n follows socket at once", {7'b0, irq_n}, 8'h00);
    sock_irq = 4'b0000;
    #1 check("R2", "socket 3 released", {7'b0, irq_n}, 8'h01);
    // R1: reset mid-run drops events and mask
    @(negedge clk);
    ev_clash = 1'b1;
    @(negedge clk);
    ev_clash = 1'b0;
    #1 check("R4", "bit7 before reset", reg_rdata, 8'h80);
    rst_n = 1'b0;
    #1 check("R1", "flags after async reset", reg_rdata, 8'h00);
    reg_sel = 1'b1;
    #1 check("R1", "mask after async reset", reg_rdata, 8'h00);
    check("R1", "irq_n after async reset", {7'b0, irq_n}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule